// File: doc/BRIEF.md
# Top-3 Candidate Selector

This block sits in front of a costly classification stage and narrows its work. A stream of correlation scores comes in, one per target template. Each beat carries the score and the number of the template it belongs to. The block keeps a sorted set of the three best scores seen so far. When the final beat of a frame arrives, it emits the three winning template numbers, best first, so that the later stage only has to process those three. With twelve templates and three kept, that stage does about a quarter of the work it would otherwise do.

Each beat is ranked into the set in the clock that accepts it. The output is a short burst of three valid cycles. After the burst the set empties, ready for the next frame.

A frame whose length is not twelve beats sets a sticky error flag. The candidates from that frame are still emitted.

Top module: `topk_cand_sel`

## Requirements
- R1: After reset, `out_valid` and `count_err` are 0 and the kept set is empty.
- R2: Scores are signed 16-bit two's-complement values and indices are 4-bit unsigned. A higher score ranks above a lower one. For equal scores, the smaller index ranks higher.
- R3: A beat with `in_valid` high, accepted while no output burst is in progress, is placed in the sorted set in the same clock. Beats may arrive on every cycle.
- R4: Only the three best-ranked beats of a frame are kept. All others are discarded.
- R5: Suppose the beat with `in_last` high is accepted at clock edge E. Then on the three cycles after E, `out_idx` presents the kept indices in rank order, best first. `out_valid` is high on the first min(beats received, 3) of those cycles and low on the others.
- R6: After the burst, the kept set and the beat count are cleared, so the next frame's result does not depend on earlier frames.
- R7: `count_err` becomes 1 on the cycle after a last beat whose frame, last beat included, did not hold exactly 12 accepted beats. It stays 1 until reset. Candidates from that frame are still output.
- R8: Input beats presented while an output burst is in progress are ignored. They change neither the kept set nor the beat count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Score beat present |
| in_last | input | 1 | Final beat of the frame |
| in_score | input | 16 | Signed correlation score |
| in_idx | input | 4 | Template index of the score |
| out_valid | output | 1 | Candidate index valid |
| out_idx | output | 4 | Candidate index, best first |
| count_err | output | 1 | Sticky frame-length error |

## Verification
The hardest case to reach from the ports is a beat that arrives while a burst is draining. Such a beat would win the ranking if it were accepted. The stimulus creates this case by driving the largest possible score, with index 15, on every cycle of a burst. It then runs a frame of small negative scores and checks that index 15 never appears in the output. Tie order is forced by frames of equal scores whose indices arrive in descending order. The error flag is driven by frames that are too short and too long, followed by a correct frame that must leave the flag set.

// File: rtl/topk_pkg.sv
package topk_pkg;
  localparam int SCORE_W = 16;
  localparam int IDX_W   = 4;

  typedef logic signed [SCORE_W-1:0] score_t;
  typedef logic [IDX_W-1:0]          idx_t;

  typedef struct packed {
    logic   vld;
    score_t score;
    idx_t   idx;
  } cand_t;

  // True when candidate a ranks strictly above candidate b.
  function automatic logic ranks_above(cand_t a, cand_t b);
    if (!a.vld) return 1'b0;
    if (!b.vld) return 1'b1;
    if ($signed(a.score) != $signed(b.score)) return $signed(a.score) > $signed(b.score);
    return a.idx < b.idx;
  endfunction
endpackage

// File: rtl/topk_insert.sv
module topk_insert import topk_pkg::*; #(
  parameter int K_KEEP = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_en,
  input  logic                  clr,
  input  cand_t                 new_c,
  output cand_t [K_KEEP-1:0]    slots
);
  cand_t [K_KEEP-1:0] slot_q, slot_d;
  logic  [K_KEEP-1:0] wins;
  logic               load;

  assign load = ins_en | clr;

  genvar g;
  generate
    for (g = 0; g < K_KEEP; g++) begin : g_slot
      assign wins[g] = ranks_above(new_c, slot_q[g]);
      if (g == 0) begin : g_head
        always_comb begin
          if (clr)          slot_d[g] = '0;
          else if (wins[g]) slot_d[g] = new_c;
          else              slot_d[g] = slot_q[g];
        end
      end else begin : g_tail
        always_comb begin
          if (clr)                        slot_d[g] = '0;
          else if (wins[g-1])             slot_d[g] = slot_q[g-1];
          else if (wins[g])               slot_d[g] = new_c;
          else                            slot_d[g] = slot_q[g];
        end
        // R2: kept entries stay packed and in rank order
        assert_sorted_R2: assert property (@(posedge clk) disable iff (!rst_n)
          slot_q[g].vld |-> (slot_q[g-1].vld && !ranks_above(slot_q[g], slot_q[g-1])));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    slot_q <= '0;
    else if (load) slot_q <= slot_d;
  end

  assign slots = slot_q;

  // R3: a beat into an empty set is visible at the head one clock later
  assert_insert_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !clr && !slot_q[0].vld) |=> (slot_q[0].vld && slot_q[0].idx == $past(new_c.idx)));
endmodule

// File: rtl/topk_count.sv
module topk_count #(
  parameter int N_TGT = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat_en,
  input  logic last_en,
  output logic err
);
  localparam int          CW   = $clog2(N_TGT + 2);
  localparam logic [CW-1:0] CMAX = '1;
  localparam logic [CW-1:0] CEXP = CW'(N_TGT);

  logic [CW-1:0] cnt_q, cnt_d, cnt_inc;
  logic          err_q, err_d;

  always_comb begin
    cnt_inc = (cnt_q == CMAX) ? CMAX : cnt_q + 1'b1;
    cnt_d   = cnt_q;
    err_d   = err_q;
    if (last_en) begin
      cnt_d = '0;
      if (cnt_inc != CEXP) err_d = 1'b1;
    end else if (beat_en) begin
      cnt_d = cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (beat_en) cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign err = err_q;

  // R7: the error flag never falls without reset
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/topk_drain.sv
module topk_drain import topk_pkg::*; #(
  parameter int K_KEEP = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  cand_t [K_KEEP-1:0]   slots,
  output logic                 busy,
  output logic                 done,
  output logic                 out_valid,
  output idx_t                 out_idx
);
  localparam int              PW   = $clog2(K_KEEP + 1);
  localparam logic [PW-1:0]   PEND = PW'(K_KEEP);

  logic [PW-1:0] ph_q, ph_d;
  cand_t         sel;

  assign busy = (ph_q != '0);
  assign done = (ph_q == PEND);

  always_comb begin
    ph_d = ph_q;
    if (start)     ph_d = PW'(1);
    else if (done) ph_d = '0;
    else if (busy) ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < K_KEEP; i++)
      if (ph_q == PW'(i + 1)) sel = slots[i];
  end

  assign out_valid = busy & sel.vld;
  assign out_idx   = sel.idx;

  // R5: the last beat was just inserted, so the first burst cycle is valid
  assert_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);
endmodule

// File: rtl/topk_cand_sel.sv
module topk_cand_sel import topk_pkg::*; #(
  parameter int N_TGT  = 12,
  parameter int K_KEEP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [SCORE_W-1:0] in_score,
  input  logic [IDX_W-1:0]   in_idx,
  output logic               out_valid,
  output logic [IDX_W-1:0]   out_idx,
  output logic               count_err
);
  cand_t                new_c;
  cand_t [K_KEEP-1:0]   slots;
  logic                 accept, start, busy, done;

  assign accept = in_valid & ~busy;
  assign start  = accept & in_last;
  assign new_c  = '{vld: 1'b1, score: in_score, idx: in_idx};

  topk_insert #(.K_KEEP(K_KEEP)) u_insert (
    .clk(clk), .rst_n(rst_n), .ins_en(accept), .clr(done),
    .new_c(new_c), .slots(slots)
  );

  topk_count #(.N_TGT(N_TGT)) u_count (
    .clk(clk), .rst_n(rst_n), .beat_en(accept), .last_en(start), .err(count_err)
  );

  topk_drain #(.K_KEEP(K_KEEP)) u_drain (
    .clk(clk), .rst_n(rst_n), .start(start), .slots(slots),
    .busy(busy), .done(done), .out_valid(out_valid), .out_idx(out_idx)
  );

  // R6: the end of a burst leaves the kept set empty
  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !slots[0].vld);

  // R8: beats offered mid-burst do not disturb the kept set
  assert_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && in_valid) |=> $stable(slots));
endmodule

// File: tb/sim_topk_cand_sel.sv
module sim_topk_cand_sel;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_last;
  logic [15:0] in_score;
  logic [3:0]  in_idx;
  logic        out_valid;
  logic [3:0]  out_idx;
  logic        count_err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit err_exp = 0;
  int sc [16];
  int ix [16];

  always #4 clk = ~clk;

  topk_cand_sel u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_score(in_score), .in_idx(in_idx), .out_valid(out_valid),
    .out_idx(out_idx), .count_err(count_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference ranking: repeated best-of-remaining search
  task automatic ref_top(input int n, output int e [3], output int ne);
    bit used [16];
    for (int i = 0; i < 16; i++) used[i] = 0;
    ne = (n < 3) ? n : 3;
    for (int r = 0; r < 3; r++) begin
      int b = -1;
      e[r] = 0;
      for (int i = 0; i < n; i++)
        if (!used[i] && (b < 0 || sc[i] > sc[b] || (sc[i] == sc[b] && ix[i] < ix[b]))) b = i;
      if (r < ne) begin used[b] = 1; e[r] = ix[b]; end
    end
  endtask

  task automatic run_frame(input string tag, input int n, input bit inject);
    int e [3];
    int ne;
    ref_top(n, e, ne);
    if (n != 12) err_exp = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_score = 16'(sc[i]);
      in_idx   = 4'(ix[i]);
      in_last  = (i == n - 1);
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (inject) begin
        in_valid = 1'b1; in_last = 1'b1; in_score = 16'h7fff; in_idx = 4'd15;
      end else begin
        in_valid = 1'b0; in_last = 1'b0;
      end
      if (k == 0) check(count_err == err_exp, "R7", int'(count_err), int'(err_exp), {tag, " error flag"});
      check(out_valid == (k < ne), "R5", int'(out_valid), int'(k < ne), {tag, " burst valid"});
      if (k < ne) check(out_idx == 4'(e[k]), "R2", int'(out_idx), e[k], $sformatf("%s rank %0d (R4)", tag, k));
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check(out_valid == 1'b0, "R5", int'(out_valid), 0, {tag, " burst end"});
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    err_exp = 0;
    check(out_valid == 1'b0, "R1", int'(out_valid), 0, "reset out_valid");
    check(count_err == 1'b0, "R1", int'(count_err), 0, "reset count_err");
  endtask

  task automatic t_ascending();
    for (int i = 0; i < 12; i++) begin sc[i] = i * 100 - 500; ix[i] = i; end
    run_frame("ascending R3", 12, 0);
  endtask

  task automatic t_signed();
    for (int i = 0; i < 12; i++) begin sc[i] = -32768 + i * 5; ix[i] = 11 - i; end
    sc[3] = -2; sc[6] = -1; sc[9] = 0; sc[1] = 32767;
    run_frame("signed", 12, 0);
  endtask

  task automatic t_ties();
    for (int i = 0; i < 12; i++) begin sc[i] = 42; ix[i] = 11 - i; end
    run_frame("all-equal ties", 12, 0);
    for (int i = 0; i < 12; i++) begin sc[i] = (i % 4 == 0) ? 500 : 100; ix[i] = (i * 7) % 12; end
    run_frame("grouped ties", 12, 0);
  endtask

  task automatic t_ignore();
    for (int i = 0; i < 12; i++) begin sc[i] = 1000 + i; ix[i] = i; end
    run_frame("inject during burst R8", 12, 1);
    for (int i = 0; i < 12; i++) begin sc[i] = -i - 3; ix[i] = (i * 5) % 12; end
    run_frame("after inject R6 R8", 12, 0);
  endtask

  task automatic t_length();
    sc[0] = 10; ix[0] = 4; sc[1] = 20; ix[1] = 9;
    run_frame("short frame R7", 2, 0);
    for (int i = 0; i < 12; i++) begin sc[i] = (i * 37) % 19 - 9; ix[i] = i; end
    run_frame("full frame sticky R7", 12, 0);
    for (int i = 0; i < 14; i++) begin sc[i] = 7 * i - 40; ix[i] = i; end
    run_frame("long frame R7", 14, 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_score = '0; in_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(out_valid == 1'b0, "R1", int'(out_valid), 0, "power-up out_valid");
    check(count_err == 1'b0, "R1", int'(count_err), 0, "power-up count_err");
    t_ascending();
    t_signed();
    t_ties();
    t_ignore();
    t_length();
    t_reset();
    t_ascending();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule